// File: doc/BRIEF.md
# Update-Mode Access Guard for a Firmware-Driven IP

This block wraps one microcontroller-based IP. Other bus initiators reach the IP through it, and it also answers a central update sequencer. The sequencer talks to it over a command channel: a one-cycle command with an opcode, an address and a data word. One cycle later the block returns a registered reply with a status code and a data word. The command channel is the packet boundary. The block turns each command into signals at the IP's port and packs the IP's answers into the reply.

During boot the sequencer writes a policy configuration word. It can then read back identity metadata: firmware version, the stored configuration, compatibility requirements and controller model. It can also fetch the credential that the IP generates, which the block passes through unchanged.

For an image update the sequencer first moves the block into update mode. The block confirms this in its reply. From that cycle until the completion acknowledgement, every request from other initiators is refused at once with an error, and only the sequencer's image-load writes reach the IP. A completion command puts the block back in operational mode and acknowledges it, and normal access resumes.

Top module: `upd_guard`

## Requirements
- R1: After reset the block is in operational mode (`upd_mode` = 0), the configuration word is zero and no configuration has been written. Until a configuration is written, every defined opcode other than CONFIG (0) is answered with status REJECT (2) and reply data 0, and changes no state.
- R2: Every command produces `rsp_valid` for exactly one cycle, in the cycle after the command. CONFIG (opcode 0) outside update mode stores `cmd_data` as the configuration word and replies OK (0).
- R3: META (opcode 1) replies OK. `cmd_data[1:0]` selects the reply data: 0 gives the firmware version, 1 the stored configuration word, 2 the compatibility code, 3 the controller model. Each field is zero-extended to the data width.
- R4: AUTH (opcode 2) replies OK, and its data is the IP's credential exactly as it was in the command cycle.
- R5: ENTER (opcode 3) in operational mode, once configured, sets `upd_mode` and replies OK. The confirmation and the mode change appear in the same cycle.
- R6: While `upd_mode` is 1, any bus request gets `bus_err` = 1 and `bus_rdata` = 0 in that same cycle, and no bus request reaches the IP port.
- R7: While `upd_mode` is 0, a bus request passes to the IP port unchanged (request, write enable, address, write data) with `bus_err` = 0, and `bus_rdata` equals `ip_rdata`.
- R8: LOAD (opcode 4) in update mode drives a write to the IP port in the command cycle, using `cmd_addr` and `cmd_data`, and replies OK. Outside update mode it replies REJECT and no IP write occurs.
- R9: DONE (opcode 5) in update mode clears `upd_mode` and replies OK as the completion acknowledgement. Outside update mode it replies REJECT.
- R10: In update mode, ENTER and CONFIG reply BUSY (1) and are otherwise ignored: the mode stays set and the configuration word is kept.
- R11: Opcodes 6 and 7 reply ILLEGAL (3) with data 0 in any state and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Sequencer command strobe, one cycle per command |
| cmd_op | input | 3 | Command opcode |
| cmd_addr | input | AW | Image-load address |
| cmd_data | input | DW | Configuration word, metadata selector or image data |
| rsp_valid | output | 1 | Reply strobe, one cycle after a command |
| rsp_status | output | 2 | Reply status: 0 OK, 1 BUSY, 2 REJECT, 3 ILLEGAL |
| rsp_data | output | DW | Reply data (metadata or credential, else 0) |
| upd_mode | output | 1 | 1 while in update mode |
| bus_req | input | 1 | Request from another initiator |
| bus_we | input | 1 | Write enable of that request |
| bus_addr | input | AW | Address of that request |
| bus_wdata | input | DW | Write data of that request |
| bus_rdata | output | DW | Read data returned to the initiator |
| bus_err | output | 1 | Same-cycle error for a blocked request |
| ip_req | output | 1 | Request to the wrapped IP |
| ip_we | output | 1 | Write enable to the wrapped IP |
| ip_addr | output | AW | Address to the wrapped IP |
| ip_wdata | output | DW | Write data to the wrapped IP |
| ip_rdata | input | DW | Read data from the wrapped IP |
| ip_version | input | FW | Firmware version from the IP |
| ip_compat | input | FW | Compatibility code from the IP |
| ip_model | input | FW | Controller model code from the IP |
| ip_cred | input | DW | Credential generated by the IP |

## Verification
The bench builds the block with a 16-bit data word, an 8-bit address and 6-bit metadata fields. Because the fields are narrower than the data word, a missing zero-extension in the metadata reply shows up in the returned data, and the four field selects each return a different pattern. A 16-bit credential and configuration word keep the expected values easy to state while still covering every reply bit. The small address width lets a single address value check the load path and the pass-through path.

// File: rtl/upd_guard_pkg.sv
package upd_guard_pkg;

  localparam logic [2:0] OP_CFG   = 3'd0;
  localparam logic [2:0] OP_META  = 3'd1;
  localparam logic [2:0] OP_AUTH  = 3'd2;
  localparam logic [2:0] OP_ENTER = 3'd3;
  localparam logic [2:0] OP_LOAD  = 3'd4;
  localparam logic [2:0] OP_DONE  = 3'd5;
  localparam logic [2:0] OP_LAST  = OP_DONE;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_BUSY    = 2'd1,
    ST_REJECT  = 2'd2,
    ST_ILLEGAL = 2'd3
  } status_e;

  // Decide the reply status of one command from the current state.
  function automatic status_e judge(input logic [2:0] op,
                                    input logic       configured,
                                    input logic       upd);
    status_e st;
    if (op > OP_LAST)                     st = ST_ILLEGAL;
    else if (!configured && op != OP_CFG) st = ST_REJECT;
    else begin
      case (op)
        OP_CFG, OP_ENTER: st = upd ? ST_BUSY : ST_OK;
        OP_LOAD, OP_DONE: st = upd ? ST_OK   : ST_REJECT;
        default:          st = ST_OK;
      endcase
    end
    return st;
  endfunction

endpackage

// File: rtl/upd_guard_meta.sv
module upd_guard_meta #(
  parameter int DW = 32,
  parameter int FW = 8
) (
  input  logic [2:0]    op,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] cfg,
  input  logic [FW-1:0] version,
  input  logic [FW-1:0] compat,
  input  logic [FW-1:0] model,
  input  logic [DW-1:0] cred,
  output logic [DW-1:0] qdata
);
  import upd_guard_pkg::*;

  localparam int PADW = DW - FW;

  function automatic logic [DW-1:0] widen(input logic [FW-1:0] f);
    return {{PADW{1'b0}}, f};
  endfunction

  logic [DW-1:0] meta_word;

  always_comb begin
    case (sel)
      2'd0:    meta_word = widen(version);
      2'd1:    meta_word = cfg;
      2'd2:    meta_word = widen(compat);
      default: meta_word = widen(model);
    endcase
  end

  always_comb begin
    if (op == OP_META)      qdata = meta_word;
    else if (op == OP_AUTH) qdata = cred;
    else                    qdata = '0;
  end

endmodule

// File: rtl/upd_guard_ctrl.sv
module upd_guard_ctrl #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [DW-1:0] cmd_data,
  input  logic [DW-1:0] qdata,
  output logic          rsp_valid,
  output logic [1:0]    rsp_status,
  output logic [DW-1:0] rsp_data,
  output logic          upd_mode,
  output logic          configured,
  output logic [DW-1:0] cfg_q,
  output logic          seq_load
);
  import upd_guard_pkg::*;

  status_e st;
  logic    accepted;
  logic    ev_cfg;
  logic    ev_enter;
  logic    ev_done;
  logic    is_query;

  assign st       = judge(cmd_op, configured, upd_mode);
  assign accepted = cmd_valid && (st == ST_OK);
  assign ev_cfg   = accepted && (cmd_op == OP_CFG);
  assign ev_enter = accepted && (cmd_op == OP_ENTER);
  assign ev_done  = accepted && (cmd_op == OP_DONE);
  assign seq_load = accepted && (cmd_op == OP_LOAD);
  assign is_query = (cmd_op == OP_META) || (cmd_op == OP_AUTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_mode   <= 1'b0;
      configured <= 1'b0;
      cfg_q      <= '0;
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_data   <= '0;
    end else begin
      rsp_valid <= cmd_valid;
      if (cmd_valid) begin
        rsp_status <= st;
        rsp_data   <= (accepted && is_query) ? qdata : '0;
      end
      if (ev_cfg) begin
        cfg_q      <= cmd_data;
        configured <= 1'b1;
      end
      if (ev_enter)     upd_mode <= 1'b1;
      else if (ev_done) upd_mode <= 1'b0;
    end
  end

endmodule

// File: rtl/upd_guard_port.sv
module upd_guard_port #(
  parameter int DW = 32,
  parameter int AW = 12
) (
  input  logic          upd_mode,
  input  logic          seq_load,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_err,
  output logic          ip_req,
  output logic          ip_we,
  output logic [AW-1:0] ip_addr,
  output logic [DW-1:0] ip_wdata,
  input  logic [DW-1:0] ip_rdata,
  output logic          acc_blocked
);

  assign acc_blocked = upd_mode && bus_req;

  always_comb begin
    if (upd_mode) begin
      ip_req    = seq_load;
      ip_we     = seq_load;
      ip_addr   = cmd_addr;
      ip_wdata  = cmd_data;
      bus_err   = bus_req;
      bus_rdata = '0;
    end else begin
      ip_req    = bus_req;
      ip_we     = bus_we;
      ip_addr   = bus_addr;
      ip_wdata  = bus_wdata;
      bus_err   = 1'b0;
      bus_rdata = ip_rdata;
    end
  end

endmodule

// File: rtl/upd_guard.sv
module upd_guard #(
  parameter int DW = 32,
  parameter int AW = 12,
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  output logic          rsp_valid,
  output logic [1:0]    rsp_status,
  output logic [DW-1:0] rsp_data,
  output logic          upd_mode,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_err,
  output logic          ip_req,
  output logic          ip_we,
  output logic [AW-1:0] ip_addr,
  output logic [DW-1:0] ip_wdata,
  input  logic [DW-1:0] ip_rdata,
  input  logic [FW-1:0] ip_version,
  input  logic [FW-1:0] ip_compat,
  input  logic [FW-1:0] ip_model,
  input  logic [DW-1:0] ip_cred
);

  logic [DW-1:0] qdata;
  logic [DW-1:0] cfg_q;
  logic          configured;
  logic          seq_load;
  logic          acc_blocked;

  upd_guard_meta #(.DW(DW), .FW(FW)) meta_i (
    .op(cmd_op), .sel(cmd_data[1:0]), .cfg(cfg_q),
    .version(ip_version), .compat(ip_compat), .model(ip_model),
    .cred(ip_cred), .qdata(qdata)
  );

  upd_guard_ctrl #(.DW(DW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .qdata(qdata), .rsp_valid(rsp_valid),
    .rsp_status(rsp_status), .rsp_data(rsp_data), .upd_mode(upd_mode),
    .configured(configured), .cfg_q(cfg_q), .seq_load(seq_load)
  );

  upd_guard_port #(.DW(DW), .AW(AW)) port_i (
    .upd_mode(upd_mode), .seq_load(seq_load), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .ip_req(ip_req), .ip_we(ip_we), .ip_addr(ip_addr),
    .ip_wdata(ip_wdata), .ip_rdata(ip_rdata), .acc_blocked(acc_blocked)
  );

endmodule

// File: rtl/upd_guard_chk.sv
module upd_guard_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [2:0]    cmd_op,
  input logic          rsp_valid,
  input logic [1:0]    rsp_status,
  input logic [DW-1:0] rsp_data,
  input logic          upd_mode,
  input logic          bus_req,
  input logic          bus_err,
  input logic          ip_req,
  input logic [DW-1:0] ip_cred,
  input logic          configured,
  input logic          seq_load,
  input logic          acc_blocked
);
  import upd_guard_pkg::*;

  // R2: one reply for every command, in the next cycle
  a_r2_reply_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);

  // R1: unconfigured block refuses every defined opcode except CONFIG
  a_r1_unconf_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !configured && cmd_op != OP_CFG && cmd_op <= OP_LAST)
    |=> (rsp_status == ST_REJECT));

  // R4: credential returned unchanged
  a_r4_cred_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && configured && cmd_op == OP_AUTH)
    |=> (rsp_data == $past(ip_cred)));

  // R5: confirmation and mode change arrive together
  a_r5_enter_confirm: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && configured && !upd_mode && cmd_op == OP_ENTER)
    |=> (upd_mode && rsp_valid && rsp_status == ST_OK));

  // R6: foreign requests refused in update mode
  a_r6_block_err: assert property (@(posedge clk) disable iff (!rst_n)
    acc_blocked |-> bus_err);

  // R6: only sequencer loads reach the IP in update mode
  a_r6_ip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_mode && !seq_load) |-> !ip_req);

  // R7: operational mode never raises an error
  a_r7_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_mode |-> (!bus_err && ip_req == bus_req));

  // R9: completion acknowledged and mode released
  a_r9_done_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && upd_mode && cmd_op == OP_DONE)
    |=> (!upd_mode && rsp_status == ST_OK));

  // R10: second ENTER answered busy, mode held
  a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && upd_mode && cmd_op == OP_ENTER)
    |=> (upd_mode && rsp_status == ST_BUSY));

  // R11: undefined opcodes answered illegal without state change
  a_r11_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op > OP_LAST)
    |=> (rsp_status == ST_ILLEGAL && $stable(upd_mode)));

endmodule

bind upd_guard upd_guard_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_data(rsp_data),
  .upd_mode(upd_mode), .bus_req(bus_req), .bus_err(bus_err),
  .ip_req(ip_req), .ip_cred(ip_cred), .configured(configured),
  .seq_load(seq_load), .acc_blocked(acc_blocked)
);

// File: tb/upd_guard_tb_top.sv
`timescale 1ns/1ps
module upd_guard_tb_top;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int FW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic          rsp_valid;
  logic [1:0]    rsp_status;
  logic [DW-1:0] rsp_data;
  logic          upd_mode;
  logic          bus_req = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          bus_err;
  logic          ip_req, ip_we;
  logic [AW-1:0] ip_addr;
  logic [DW-1:0] ip_wdata;
  logic [DW-1:0] ip_rdata   = 16'h1234;
  logic [FW-1:0] ip_version = 6'h2A;
  logic [FW-1:0] ip_compat  = 6'h15;
  logic [FW-1:0] ip_model   = 6'h33;
  logic [DW-1:0] ip_cred    = 16'hBEEF;

  int checks = 0;
  int errors = 0;

  logic [1:0]    exp_st_q[$];
  logic [DW-1:0] exp_d_q[$];
  string         exp_tag_q[$];

  always #2 clk = ~clk;

  upd_guard #(.DW(DW), .AW(AW), .FW(FW)) dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops one expected reply per observed reply.
  initial begin
    forever begin
      @(posedge clk); #1;
      if (rst_n && rsp_valid) begin
        if (exp_st_q.size() == 0) begin
          check("R2 unexpected reply", 32'd1, 32'd0);
        end else begin
          string tag;
          tag = exp_tag_q.pop_front();
          check({tag, " status"}, 32'(rsp_status), 32'(exp_st_q.pop_front()));
          check({tag, " data"}, 32'(rsp_data), 32'(exp_d_q.pop_front()));
        end
      end
    end
  end

  // Driver: start a command at a falling edge and push its expected reply.
  task automatic cmd_start(input logic [2:0] op, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input logic [1:0] est,
                           input logic [DW-1:0] ed, input string tag);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    exp_st_q.push_back(est); exp_d_q.push_back(ed); exp_tag_q.push_back(tag);
    #1;
  endtask

  task automatic cmd_end();
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic send(input logic [2:0] op, input logic [DW-1:0] d,
                      input logic [1:0] est, input logic [DW-1:0] ed, input string tag);
    cmd_start(op, '0, d, est, ed, tag);
    cmd_end();
  endtask

  initial begin
    #(4 * 20000);
    check("watchdog expired", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset mode", 32'(upd_mode), 32'd0);
    check("R1 reset no reply", 32'(rsp_valid), 32'd0);

    // R1: commands refused before configuration
    send(3'd1, 16'd1, 2'd2, 16'h0, "R1 meta unconfigured");
    send(3'd3, 16'd0, 2'd2, 16'h0, "R1 enter unconfigured");
    check("R1 mode after refused enter", 32'(upd_mode), 32'd0);
    send(3'd1, 16'd1, 2'd2, 16'h0, "R1 config still zero");
    // R11: undefined opcodes
    send(3'd6, 16'h0, 2'd3, 16'h0, "R11 opcode 6");
    send(3'd7, 16'h0, 2'd3, 16'h0, "R11 opcode 7");

    // R7: pass-through in operational mode
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = 8'h10; bus_wdata = 16'hA5A5; #1;
    check("R7 ip_req", 32'(ip_req), 32'd1);
    check("R7 ip_we", 32'(ip_we), 32'd1);
    check("R7 ip_addr", 32'(ip_addr), 32'h10);
    check("R7 ip_wdata", 32'(ip_wdata), 32'hA5A5);
    check("R7 bus_err", 32'(bus_err), 32'd0);
    check("R7 rdata", 32'(bus_rdata), 32'h1234);
    @(negedge clk); bus_req = 0; bus_we = 0;

    // R2/R3/R4: configuration and queries
    send(3'd0, 16'h00C3, 2'd0, 16'h0, "R2 config");
    send(3'd1, 16'd0, 2'd0, 16'h002A, "R3 version");
    send(3'd1, 16'd1, 2'd0, 16'h00C3, "R3 config field");
    send(3'd1, 16'd2, 2'd0, 16'h0015, "R3 compat");
    send(3'd1, 16'd3, 2'd0, 16'h0033, "R3 model");
    send(3'd2, 16'd0, 2'd0, 16'hBEEF, "R4 credential");
    ip_cred = 16'h0F0F;
    send(3'd2, 16'd0, 2'd0, 16'h0F0F, "R4 credential changed");

    // R5: enter update mode
    send(3'd3, 16'd0, 2'd0, 16'h0, "R5 enter confirm");
    check("R5 mode set", 32'(upd_mode), 32'd1);

    // R6: foreign requests refused
    bus_req = 1; bus_we = 0; bus_addr = 8'h11; #1;
    check("R6 bus_err read", 32'(bus_err), 32'd1);
    check("R6 ip_req", 32'(ip_req), 32'd0);
    check("R6 rdata zero", 32'(bus_rdata), 32'd0);
    bus_we = 1; #1;
    check("R6 bus_err write", 32'(bus_err), 32'd1);
    check("R6 ip_we", 32'(ip_we), 32'd0);
    bus_req = 0; bus_we = 0;

    // R10: busy while updating
    send(3'd3, 16'd0, 2'd1, 16'h0, "R10 enter busy");
    check("R10 mode held", 32'(upd_mode), 32'd1);
    send(3'd0, 16'h0077, 2'd1, 16'h0, "R10 config busy");
    send(3'd1, 16'd1, 2'd0, 16'h00C3, "R10 config kept");

    // R8: image load while a foreign request is pending
    bus_req = 1; bus_we = 1; bus_addr = 8'h55; bus_wdata = 16'hDEAD;
    cmd_start(3'd4, 8'h20, 16'h7E57, 2'd0, 16'h0, "R8 load");
    check("R8 ip_req", 32'(ip_req), 32'd1);
    check("R8 ip_we", 32'(ip_we), 32'd1);
    check("R8 ip_addr", 32'(ip_addr), 32'h20);
    check("R8 ip_wdata", 32'(ip_wdata), 32'h7E57);
    check("R6 err during load", 32'(bus_err), 32'd1);
    cmd_end();
    bus_req = 0; bus_we = 0;

    // R9: completion
    send(3'd5, 16'd0, 2'd0, 16'h0, "R9 done ack");
    check("R9 mode cleared", 32'(upd_mode), 32'd0);
    bus_req = 1; bus_we = 0; bus_addr = 8'h12; #1;
    check("R7 access restored err", 32'(bus_err), 32'd0);
    check("R7 access restored req", 32'(ip_req), 32'd1);
    bus_req = 0;

    // R8/R9 outside update mode
    cmd_start(3'd4, 8'h21, 16'h1111, 2'd2, 16'h0, "R8 load rejected");
    check("R8 no ip write", 32'(ip_req), 32'd0);
    cmd_end();
    send(3'd5, 16'd0, 2'd2, 16'h0, "R9 done rejected");
    send(3'd6, 16'd0, 2'd3, 16'h0, "R11 illegal configured");
    check("R11 mode unchanged", 32'(upd_mode), 32'd0);

    repeat (3) @(negedge clk);
    check("R2 all replies seen", 32'(exp_st_q.size()), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule